// File: doc/BRIEF.md
# Change-Only State Capture Compressor

This block sits behind the sampling front end of a logic state analyzer. It watches a wide state bus on every enabled sample clock and keeps one working record: the state now held and a count of how many qualified samples that state has lasted. A record leaves the block only when something ends that state. This happens when a different state arrives, when the count can grow no further, or when a flush closes the capture. A state that stays unchanged for thousands of samples therefore takes one entry of capture memory instead of thousands.

A window qualifier sits in front of the compressor. An address field inside the state word is compared against a set of programmable windows, each with its own enable. Samples outside every enabled window are dropped before they can touch the working record. Records go to a FIFO-style write port that honours a full signal. A record that falls due while the FIFO is full is discarded, and a sticky loss flag is raised until it is cleared.

Top module: `xition_capture`

## Requirements
- R1: The first qualified sample after reset, or after a flush, opens a state with a count of 1 and writes no record.
- R2: A qualified sample equal to the held state writes no record and adds one to the count. A qualified sample that differs writes one record holding the prior state in bits [STATE_W+CNT_W-1:CNT_W] and its count in bits [CNT_W-1:0], so with default widths the state is in 63:32 and the duration in 31:0.
- R3: Whenever a new state opens, its count starts at 1.
- R4: A sample is qualified when `smp_en` is high and its address field `state_in[ADDR_LO+ADDR_W-1:ADDR_LO]` lies in at least one window i whose `win_en[i]` is set. Window i has lower bound `win_lo[i*ADDR_W +: ADDR_W]` and upper bound `win_hi[i*ADDR_W +: ADDR_W]`, and both bounds are inclusive. Any other sample changes neither the count nor the state and writes nothing.
- R5: When the count equals its all-ones maximum and another identical qualified sample arrives, a record with the maximum count is written and the count restarts at 1.
- R6: A flush while a state is held writes that state with its partial count, and the next qualified sample then opens a state under R1. A flush with no state held writes nothing.
- R7: When a flush and a qualified sample fall in the same cycle, the record carries the state and count from before that cycle. The sample then opens a new state with count 1, even if it equals the flushed state.
- R8: `rec_wr` is never high while `rec_full` is high. A record due while full is lost, and `ovf` is high from the next cycle.
- R9: `ovf` stays high until a cycle with `ovf_clr` high and no new loss. When a loss and a clear coincide, `ovf` stays high.
- R10: During reset `rec_wr` and `ovf` are low and no state is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_en | input | 1 | Sample enable; a sample is taken only in cycles where it is high |
| state_in | input | STATE_W | Sampled state bus |
| win_en | input | NUM_WIN | Enable for each address window |
| win_lo | input | NUM_WIN*ADDR_W | Packed inclusive lower bounds, window i at slice i |
| win_hi | input | NUM_WIN*ADDR_W | Packed inclusive upper bounds, window i at slice i |
| flush | input | 1 | Close the held state and write it out |
| ovf_clr | input | 1 | Clear the sticky loss flag |
| rec_full | input | 1 | Downstream FIFO full |
| rec_wr | output | 1 | Record write strobe |
| rec_data | output | STATE_W+CNT_W | Record: state high, duration low |
| ovf | output | 1 | Sticky record-loss flag |

## Verification
A flush can fall in the same cycle as a qualified sample, and the two then compete for the working record. The bench drives a flush together with a differing sample, and again together with a sample equal to the held state. It expects exactly one record carrying the state and count from before that cycle, followed by a count that restarts at 1. The same sort of collision is provoked between a loss and `ovf_clr` to check that the flag stays set. The bench's scoreboard model settles every expected record and flag value without looking inside the design.

// File: rtl/xc_pkg.sv
package xc_pkg;

  // Inclusive window test; operands are zero-extended to 32 bits by the caller.
  function automatic logic addr_in_window(input logic [31:0] addr,
                                          input logic [31:0] lo,
                                          input logic [31:0] hi);
    return (addr >= lo) && (addr <= hi);
  endfunction

  // A state closes when it differs, when the count is spent, or on a flush.
  function automatic logic state_closes(input logic differs,
                                        input logic cnt_spent,
                                        input logic flush_req);
    return differs || cnt_spent || flush_req;
  endfunction

endpackage

// File: rtl/xc_window_qual.sv
module xc_window_qual #(
  parameter int ADDR_W  = 16,
  parameter int NUM_WIN = 2
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NUM_WIN-1:0]        win_en,
  input  logic [NUM_WIN*ADDR_W-1:0] win_lo,
  input  logic [NUM_WIN*ADDR_W-1:0] win_hi,
  output logic                      hit
);
  import xc_pkg::*;

  logic [NUM_WIN-1:0] win_hit;

  generate
    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
      assign win_hit[gi] = win_en[gi] &&
                           addr_in_window(32'(addr),
                                          32'(win_lo[gi*ADDR_W +: ADDR_W]),
                                          32'(win_hi[gi*ADDR_W +: ADDR_W]));
    end
  endgenerate

  assign hit = |win_hit;

endmodule

// File: rtl/xc_state_track.sv
module xc_state_track #(
  parameter int STATE_W = 32,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               flush,
  input  logic [STATE_W-1:0] state_in,
  output logic               have_state,
  output logic [STATE_W-1:0] cur_state,
  output logic [CNT_W-1:0]   cur_cnt,
  output logic               emit_due
);
  import xc_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic differs;
  logic cnt_spent;
  logic flush_hit;
  logic change_hit;
  logic sat_hit;
  logic restart;

  assign differs    = (state_in != cur_state);
  assign cnt_spent  = (cur_cnt == CNT_MAX);
  assign flush_hit  = flush && have_state;
  assign change_hit = take && have_state && differs;
  assign sat_hit    = take && have_state && !differs && cnt_spent;
  assign emit_due   = flush_hit || change_hit || sat_hit;
  assign restart    = !have_state || state_closes(differs, cnt_spent, flush);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_state <= 1'b0;
      cur_state  <= '0;
      cur_cnt    <= '0;
    end else if (take) begin
      have_state <= 1'b1;
      cur_state  <= state_in;
      cur_cnt    <= restart ? CNT_ONE : cur_cnt + CNT_ONE;
    end else if (flush) begin
      have_state <= 1'b0;
    end
  end

endmodule

// File: rtl/xition_capture.sv
module xition_capture #(
  parameter int STATE_W = 32,
  parameter int CNT_W   = 32,
  parameter int ADDR_LO = 0,
  parameter int ADDR_W  = 16,
  parameter int NUM_WIN = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      smp_en,
  input  logic [STATE_W-1:0]        state_in,
  input  logic [NUM_WIN-1:0]        win_en,
  input  logic [NUM_WIN*ADDR_W-1:0] win_lo,
  input  logic [NUM_WIN*ADDR_W-1:0] win_hi,
  input  logic                      flush,
  input  logic                      ovf_clr,
  input  logic                      rec_full,
  output logic                      rec_wr,
  output logic [STATE_W+CNT_W-1:0]  rec_data,
  output logic                      ovf
);

  localparam int REC_W = STATE_W + CNT_W;

  // Named internal events, observed by the bound checker.
  logic               qual_hit;
  logic               take;
  logic               emit_due;
  logic               drop_evt;
  logic               have_state;
  logic [STATE_W-1:0] cur_state;
  logic [CNT_W-1:0]   cur_cnt;

  xc_window_qual #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) qual_i (
    .addr   (state_in[ADDR_LO +: ADDR_W]),
    .win_en (win_en),
    .win_lo (win_lo),
    .win_hi (win_hi),
    .hit    (qual_hit)
  );

  assign take = smp_en && qual_hit;

  xc_state_track #(.STATE_W(STATE_W), .CNT_W(CNT_W)) track_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .flush      (flush),
    .state_in   (state_in),
    .have_state (have_state),
    .cur_state  (cur_state),
    .cur_cnt    (cur_cnt),
    .emit_due   (emit_due)
  );

  // Every closing event writes the working record as it stood before the edge.
  assign rec_data = REC_W'({cur_state, cur_cnt});
  assign rec_wr   = emit_due && !rec_full;
  assign drop_evt = emit_due && rec_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf <= 1'b0;
    else if (drop_evt) ovf <= 1'b1;
    else if (ovf_clr)  ovf <= 1'b0;
  end

endmodule

// File: rtl/xc_checker.sv
module xc_checker #(
  parameter int STATE_W = 32,
  parameter int CNT_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               smp_en,
  input logic               flush,
  input logic               ovf_clr,
  input logic               rec_full,
  input logic               rec_wr,
  input logic               ovf,
  input logic               qual_hit,
  input logic               emit_due,
  input logic               have_state,
  input logic [STATE_W-1:0] state_in,
  input logic [STATE_W-1:0] cur_state,
  input logic [CNT_W-1:0]   cur_cnt
);

  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] CONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // R8
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_full |-> !rec_wr);

  // R8
  drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_due && rec_full) |=> ovf);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);

  // R9
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !(emit_due && rec_full)) |=> !ovf);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !(smp_en && qual_hit)) |-> !emit_due);

  // R1
  first_no_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !have_state |-> !emit_due);

  // R2
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && qual_hit && have_state && !flush &&
     state_in == cur_state && cur_cnt != CMAX) |-> !rec_wr);

  // R3
  new_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && qual_hit && (!have_state || flush || state_in != cur_state))
      |=> (cur_cnt == CONE && have_state));

endmodule

bind xition_capture xc_checker #(.STATE_W(STATE_W), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_en     (smp_en),
  .flush      (flush),
  .ovf_clr    (ovf_clr),
  .rec_full   (rec_full),
  .rec_wr     (rec_wr),
  .ovf        (ovf),
  .qual_hit   (qual_hit),
  .emit_due   (emit_due),
  .have_state (have_state),
  .state_in   (state_in),
  .cur_state  (cur_state),
  .cur_cnt    (cur_cnt)
);

// File: tb/xition_capture_tb_top.sv
module xition_capture_tb_top;

  localparam int SW = 32;
  localparam int CW = 4;
  localparam int RW = SW + CW;
  localparam logic [CW-1:0] CMAX = '1;

  typedef struct {
    logic [RW-1:0] rec;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_en = 1'b0;
  logic [SW-1:0] state_in = '0;
  logic [1:0]    win_en = 2'b00;
  logic [31:0]   win_lo = {16'h8000, 16'h0100};
  logic [31:0]   win_hi = {16'h8003, 16'h01FF};
  logic          flush = 1'b0;
  logic          ovf_clr = 1'b0;
  logic          rec_full = 1'b0;
  logic          rec_wr;
  logic [RW-1:0] rec_data;
  logic          ovf;

  xition_capture #(.STATE_W(SW), .CNT_W(CW), .ADDR_LO(0), .ADDR_W(16), .NUM_WIN(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .state_in(state_in),
    .win_en(win_en), .win_lo(win_lo), .win_hi(win_hi), .flush(flush),
    .ovf_clr(ovf_clr), .rec_full(rec_full), .rec_wr(rec_wr),
    .rec_data(rec_data), .ovf(ovf)
  );

  always #5 clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  bit    live = 0;
  exp_t  q[$];
  bit    m_have = 0;
  logic [SW-1:0] m_state = '0;
  logic [CW-1:0] m_cnt = '0;
  bit    m_ovf = 0;
  bit    exp_ovf_cur = 0;
  bit    exp_wr_cur = 0;
  string cur_tag = "R10";

  function automatic bit in_win(logic [SW-1:0] st);
    logic [15:0] a;
    a = st[15:0];
    return (win_en[0] && a >= 16'h0100 && a <= 16'h01FF) ||
           (win_en[1] && a >= 16'h8000 && a <= 16'h8003);
  endfunction

  // Driver: applies one cycle of stimulus and predicts its outcome.
  task automatic step(input bit smp, input logic [SW-1:0] st, input bit fl,
                      input bit full, input bit clr, input string tag);
    bit hit;
    bit due;
    @(posedge clk); #2;
    smp_en = smp; state_in = st; flush = fl; rec_full = full; ovf_clr = clr;
    cur_tag = tag;
    hit = smp && in_win(st);
    due = (fl && m_have) || (hit && m_have && (st != m_state || m_cnt == CMAX));
    exp_ovf_cur = m_ovf;
    exp_wr_cur  = due && !full;
    if (due && !full) q.push_back('{rec: {m_state, m_cnt}, tag: tag});
    if (due && full) m_ovf = 1;
    else if (clr)    m_ovf = 0;
    if (hit) begin
      m_cnt   = (!m_have || fl || st != m_state || m_cnt == CMAX) ? 1 : m_cnt + 1;
      m_state = st;
      m_have  = 1;
    end else if (fl) begin
      m_have = 0;
    end
  endtask

  task automatic drained(input string tag);
    @(negedge clk); #1;
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s: pending records actual=%0d expected=0", tag, q.size());
      q.delete();
    end
  endtask

  // Monitor: compares outputs mid-cycle against the scoreboard.
  always @(negedge clk) begin
    if (live) begin
      checks++;
      if (ovf !== exp_ovf_cur) begin
        errors++;
        $display("FAIL %s: ovf actual=%0b expected=%0b", cur_tag, ovf, exp_ovf_cur);
      end
      checks++;
      if (rec_wr !== exp_wr_cur) begin
        errors++;
        $display("FAIL %s: rec_wr actual=%0b expected=%0b", cur_tag, rec_wr, exp_wr_cur);
      end
      if (rec_wr && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (rec_data !== e.rec) begin
          errors++;
          $display("FAIL %s: record actual=%h expected=%h", e.tag, rec_data, e.rec);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R10 reset state
    if (rec_wr !== 1'b0 || ovf !== 1'b0) begin
      errors++;
      $display("FAIL R10: rec_wr/ovf actual=%0b/%0b expected=0/0", rec_wr, ovf);
    end
    @(posedge clk); #2;
    rst_n = 1'b1;
    win_en = 2'b11;
    live = 1;

    // R1 first sample opens a state; R2 holds, then a change writes; R3 restarts.
    step(1, 32'h0000_0100, 0, 0, 0, "R1");
    step(1, 32'h0000_0100, 0, 0, 0, "R2");
    step(1, 32'h0000_0100, 0, 0, 0, "R2");
    step(1, 32'h0000_0100, 0, 0, 0, "R2");
    step(1, 32'h0000_0150, 0, 0, 0, "R2");
    step(1, 32'h0000_0150, 0, 0, 0, "R3");
    step(1, 32'hABCD_8000, 0, 0, 0, "R3");
    drained("R2");

    // R4: out-of-window, disabled sample enable, inclusive bounds.
    step(1, 32'h0000_0500, 0, 0, 0, "R4");
    step(0, 32'h1234_0120, 0, 0, 0, "R4");
    step(1, 32'h0000_8004, 0, 0, 0, "R4");
    step(1, 32'h0000_00FF, 0, 0, 0, "R4");
    step(1, 32'hABCD_8000, 0, 0, 0, "R4");
    step(1, 32'h0000_8003, 0, 0, 0, "R4");
    step(1, 32'h0000_01FF, 0, 0, 0, "R4");
    win_en = 2'b01;
    step(1, 32'h0000_8001, 0, 0, 0, "R4");
    step(1, 32'h0000_0100, 0, 0, 0, "R4");
    win_en = 2'b11;
    drained("R4");

    // R5 saturation: change in, then 16 identical samples.
    step(1, 32'h5555_0120, 0, 0, 0, "R5");
    for (int i = 0; i < 16; i++) step(1, 32'h5555_0120, 0, 0, 0, "R5");
    step(1, 32'h5555_0120, 0, 0, 0, "R5");
    step(1, 32'h0000_0121, 0, 0, 0, "R5");
    drained("R5");

    // R6 flush alone, then a fresh start without a record, then flush with nothing held.
    step(1, 32'h0000_0121, 0, 0, 0, "R6");
    step(0, 32'h0000_0000, 1, 0, 0, "R6");
    step(1, 32'h0000_0122, 0, 0, 0, "R6");
    step(1, 32'h0000_0122, 0, 0, 0, "R6");
    step(0, 32'h0000_0000, 1, 0, 0, "R6");
    step(0, 32'h0000_0000, 1, 0, 0, "R6");
    step(1, 32'h0000_0123, 0, 0, 0, "R6");
    drained("R6");

    // R7 flush with a coincident differing sample, then with an equal sample.
    step(1, 32'h0000_0123, 0, 0, 0, "R7");
    step(1, 32'h0000_0124, 1, 0, 0, "R7");
    step(1, 32'h0000_0124, 0, 0, 0, "R7");
    step(1, 32'h0000_0124, 1, 0, 0, "R7");
    step(1, 32'h0000_0125, 0, 0, 0, "R7");
    drained("R7");

    // R8 loss while full; R9 sticky, clear, and clear colliding with a loss.
    step(1, 32'h0000_0126, 0, 1, 0, "R8");
    step(1, 32'h0000_0126, 0, 1, 0, "R9");
    step(1, 32'h0000_0127, 0, 0, 0, "R9");
    step(0, 32'h0000_0000, 0, 0, 1, "R9");
    step(0, 32'h0000_0000, 0, 0, 0, "R9");
    step(1, 32'h0000_0128, 0, 1, 1, "R9");
    step(0, 32'h0000_0000, 0, 0, 0, "R9");
    step(0, 32'h0000_0000, 0, 0, 1, "R9");
    step(0, 32'h0000_0000, 1, 1, 0, "R8");
    step(0, 32'h0000_0000, 0, 0, 0, "R8");
    drained("R8");

    live = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule